// File: doc/BRIEF.md
# DC-Predicting Dezigzag Dequantizer

This block turns one minimum coded unit (MCU) of run-length coded coefficients into full, dequantized 8x8 coefficient blocks in raster order, ready for the inverse transform. It reads the compressed elements from a shared 16-bit MCU buffer, works through six blocks of a 4:2:0 MCU (four luma, then one of each chroma), and writes each finished block back over its own region of the same buffer. Each block's region holds 64 words.

At the start of an MCU it reads each component's quantization table selection and its running DC predictor from a 16-bit state memory. It then expands the zero runs and adds each block's DC difference to the predictor of its component. It scales every coefficient by the matching quantization table entry, which it reads from an 8-bit code memory. After the last block it stores the three predictors back to the state memory. Because of this, decoding can continue with the next MCU even after the block has been reloaded. All three memories have a one-cycle read latency.

Top module: `dc_dezigzag_dequant`

## Requirements
- R1: While reset is held and afterwards until `start`, `done`, `mcuWrEn` and `stWrEn` stay low.
- R2: An input element carries the zero-run count in bits [15:12] and a 12-bit two's complement amplitude in bits [11:0]. An AC element first skips `run` zero coefficients and then places its amplitude at the next zigzag index.
- R3: The coefficient at zigzag index k is written to raster position r*8+c of the standard 8x8 zigzag walk (k=1 goes to 1, k=2 to 8, k=3 to 16). Every position not produced by an element is written as zero.
- R4: After the DC element, the word 0x0000 ends the block, and the elements that follow it are not read. An element 0xF000 produces sixteen zero coefficients.
- R5: Block n (0..5) is read from and written to MCU addresses 64*n..64*n+63, with all 64 words written in ascending address order. Blocks 0-3 belong to component 0, block 4 to component 1 and block 5 to component 2.
- R6: The first element of a block is the DC difference, and its run field is ignored. The DC coefficient is the previous predictor of that component plus the difference, wrapped to 16 bits. That value becomes the new predictor.
- R7: Component c uses table t = bits [1:0] of the state word at 0x205+c. Zigzag index k is scaled by the unsigned byte at code address 0x700+64*t+k.
- R8: The product of coefficient and table entry is saturated to the signed 16-bit range [-32768, 32767].
- R9: Predictors are loaded from state addresses 0x210, 0x211 and 0x212 (components 0, 1, 2) at `start`. After the last block they are written back to the same addresses, and the state memory receives no other writes.
- R10: `done` is a single-cycle pulse that follows the final predictor write.
- R11: A block whose elements fill all 64 coefficients without an end marker ends after its 64th coefficient, and the next block is read from its own base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing one MCU |
| done | output | 1 | One-cycle pulse when the MCU and predictors are written |
| mcuRdAddr | output | 9 | MCU buffer read address |
| mcuRdData | input | 16 | MCU buffer read data, one cycle after the address |
| mcuWrEn | output | 1 | MCU buffer write enable |
| mcuWrAddr | output | 9 | MCU buffer write address |
| mcuWrData | output | 16 | Dequantized coefficient to write |
| qRdAddr | output | 11 | Code memory read address (quantization entry) |
| qRdData | input | 8 | Quantization byte, one cycle after the address |
| stRdAddr | output | 10 | State memory read address |
| stRdData | input | 16 | State memory read data, one cycle after the address |
| stWrEn | output | 1 | State memory write enable |
| stWrAddr | output | 10 | State memory write address |
| stWrData | output | 16 | Predictor value to store |

## Verification
The embedded assertions check properties that must hold on every cycle. `done` never lasts two cycles, and MCU writes stay inside the six-block region and advance one address at a time. State writes only reach the three predictor words, and no coefficient is committed once a block has 64 of them. The values themselves can only be shown by the directed scenarios, which run whole MCUs against a reference model. These values are the raster placement, the zero filling after an end marker or a zero run, the DC chaining across blocks and across MCUs, table selection and saturation.

// File: rtl/dzq_pkg.sv
package dzq_pkg;

  localparam int COEF_W = 16;
  localparam int BLK_SIZE = 64;

  // Strobes and selectors passed from control to datapath
  typedef struct packed {
    logic       blockStart;
    logic       cfgCapture;
    logic [2:0] cfgSel;
    logic       elemDecode;
    logic       elemCommit;
    logic [1:0] comp;
    logic [5:0] wrIdx;
    logic [1:0] saveSel;
  } dqStrobe_t;

  // Walk the 8x8 grid diagonally and return the raster index per zigzag index
  function automatic logic [63:0][5:0] buildZigzag();
    logic [63:0][5:0] m;
    int r, c;
    r = 0;
    c = 0;
    for (int k = 0; k < 64; k++) begin
      m[k] = 6'(r * 8 + c);
      if (((r + c) % 2) == 0) begin
        if (c == 7) r++;
        else if (r == 0) c++;
        else begin r--; c++; end
      end else begin
        if (r == 7) c++;
        else if (c == 0) r++;
        else begin r++; c--; end
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dzq_control.sv
module dzq_control
  import dzq_pkg::*;
#(
  parameter int MCU_AW = 9,
  parameter int STATE_AW = 10,
  parameter int LUMA_BLOCKS = 4,
  parameter int CHROMA_COMPS = 2,
  parameter logic [STATE_AW-1:0] FRAME_DESC_BASE = 'h205,
  parameter logic [STATE_AW-1:0] DC_SAVE_BASE = 'h210
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                elemEnd,
  input  logic                lastPos,
  output dqStrobe_t           st,
  output logic                done,
  output logic [MCU_AW-1:0]   mcuRdAddr,
  output logic                mcuWrEn,
  output logic [MCU_AW-1:0]   mcuWrAddr,
  output logic [STATE_AW-1:0] stRdAddr,
  output logic                stWrEn,
  output logic [STATE_AW-1:0] stWrAddr
);
  localparam int BLOCKS = LUMA_BLOCKS + CHROMA_COMPS;
  localparam int BLK_W = MCU_AW - 6;
  localparam int CFG_LAST = 2 * (CHROMA_COMPS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_INIT, S_RDEL, S_DEC, S_MUL, S_WRB, S_SAVE, S_FIN
  } ctlState_t;

  ctlState_t state;
  logic [6:0] cnt;
  logic [BLK_W-1:0] blockIdx;
  logic [5:0] elemIdx;
  logic [1:0] comp;

  assign comp = (int'(blockIdx) < LUMA_BLOCKS) ? 2'd0 : 2'(int'(blockIdx) - LUMA_BLOCKS + 1);
  assign mcuRdAddr = {blockIdx, elemIdx};
  assign mcuWrAddr = {blockIdx, cnt[5:0]};
  assign stRdAddr = (cnt < 7'd3) ? FRAME_DESC_BASE + STATE_AW'(cnt)
                                 : DC_SAVE_BASE + STATE_AW'(cnt - 7'd3);
  assign stWrAddr = DC_SAVE_BASE + STATE_AW'(cnt);
  assign mcuWrEn = (state == S_WRB);
  assign stWrEn = (state == S_SAVE);
  assign done = (state == S_FIN);

  always_comb begin
    st = '0;
    st.comp = comp;
    st.wrIdx = cnt[5:0];
    st.saveSel = cnt[1:0];
    st.cfgSel = 3'(cnt - 7'd1);
    st.cfgCapture = (state == S_CFG) && (cnt != 7'd0);
    st.blockStart = (state == S_INIT);
    st.elemDecode = (state == S_DEC);
    st.elemCommit = (state == S_MUL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt <= '0;
      blockIdx <= '0;
      elemIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin state <= S_CFG; cnt <= '0; end
        S_CFG: begin
          cnt <= cnt + 7'd1;
          if (int'(cnt) == CFG_LAST) begin state <= S_INIT; blockIdx <= '0; end
        end
        S_INIT: begin elemIdx <= '0; state <= S_RDEL; end
        S_RDEL: state <= S_DEC;
        S_DEC: if (elemEnd) begin state <= S_WRB; cnt <= '0; end
               else state <= S_MUL;
        S_MUL: begin
          elemIdx <= elemIdx + 6'd1;
          if (lastPos) begin state <= S_WRB; cnt <= '0; end
          else state <= S_RDEL;
        end
        S_WRB: begin
          cnt <= cnt + 7'd1;
          if (cnt == 7'd63) begin
            cnt <= '0;
            if (int'(blockIdx) == BLOCKS - 1) state <= S_SAVE;
            else begin blockIdx <= blockIdx + 1'b1; state <= S_INIT; end
          end
        end
        S_SAVE: begin
          cnt <= cnt + 7'd1;
          if (int'(cnt) == CHROMA_COMPS) state <= S_FIN;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R5
  wr_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    mcuWrEn |-> int'(mcuWrAddr) < BLOCKS * 64);
  // R5
  wr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mcuWrEn && $past(mcuWrEn)) |-> mcuWrAddr == $past(mcuWrAddr) + 1'b1);
  // R9
  st_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWrEn |-> (stWrAddr >= DC_SAVE_BASE && stWrAddr <= DC_SAVE_BASE + STATE_AW'(CHROMA_COMPS)));
endmodule

// File: rtl/dzq_datapath.sv
module dzq_datapath
  import dzq_pkg::*;
#(
  parameter int CODE_AW = 11,
  parameter logic [CODE_AW-1:0] QTAB_BASE = 'h700
) (
  input  logic               clk,
  input  logic               rstN,
  input  dqStrobe_t          st,
  input  logic [15:0]        mcuRdData,
  input  logic [7:0]         qRdData,
  input  logic [15:0]        stRdData,
  output logic [CODE_AW-1:0] qRdAddr,
  output logic [COEF_W-1:0]  wrData,
  output logic [COEF_W-1:0]  saveData,
  output logic               elemEnd,
  output logic               lastPos
);
  localparam logic [63:0][5:0] ZZ = buildZigzag();

  logic [6:0] kReg;
  logic [5:0] kLat;
  logic [11:0] ampReg;
  logic [BLK_SIZE-1:0] filled;
  logic [COEF_W-1:0] coefBuf [BLK_SIZE];
  logic [COEF_W-1:0] pred [4];
  logic [1:0] tbl [4];

  logic [6:0] kSum;
  logic isEob;
  logic [COEF_W-1:0] dcVal;
  logic signed [16:0] mulIn;
  logic signed [25:0] prod;
  logic [COEF_W-1:0] satVal;
  logic [5:0] natPos;
  logic [1:0] cfgPredIdx;

  // Element decode: run in [15:12], amplitude in [11:0]
  assign isEob = (kReg != 7'd0) && (mcuRdData == 16'h0000);
  assign kSum = (kReg == 7'd0) ? 7'd0 : kReg + {3'b000, mcuRdData[15:12]};
  assign elemEnd = isEob || (kSum > 7'd63);
  assign qRdAddr = QTAB_BASE + CODE_AW'({tbl[st.comp], kSum[5:0]});

  // Multiply stage: table byte arrives one cycle after the address
  assign dcVal = pred[st.comp] + {{4{ampReg[11]}}, ampReg};
  assign mulIn = (kLat == 6'd0) ? {dcVal[15], dcVal} : {{5{ampReg[11]}}, ampReg};
  assign prod = mulIn * $signed({1'b0, qRdData});
  assign satVal = (prod > 26'sd32767) ? 16'h7FFF :
                  (prod < -26'sd32768) ? 16'h8000 : prod[15:0];
  assign natPos = ZZ[kLat];
  assign lastPos = (kLat == 6'd63);
  assign cfgPredIdx = 2'(st.cfgSel - 3'd3);

  assign wrData = filled[st.wrIdx] ? coefBuf[st.wrIdx] : '0;
  assign saveData = pred[st.saveSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kReg <= '0;
      kLat <= '0;
      ampReg <= '0;
      filled <= '0;
      for (int i = 0; i < 4; i++) begin
        pred[i] <= '0;
        tbl[i] <= '0;
      end
    end else begin
      if (st.blockStart) begin
        kReg <= '0;
        filled <= '0;
      end
      if (st.cfgCapture) begin
        if (st.cfgSel < 3'd3) tbl[st.cfgSel[1:0]] <= stRdData[1:0];
        else pred[cfgPredIdx] <= stRdData;
      end
      if (st.elemDecode && !elemEnd) begin
        ampReg <= mcuRdData[11:0];
        kLat <= kSum[5:0];
      end
      if (st.elemCommit) begin
        filled[natPos] <= 1'b1;
        kReg <= {1'b0, kLat} + 7'd1;
        if (kLat == 6'd0) pred[st.comp] <= dcVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.elemCommit) coefBuf[natPos] <= satVal;
  end

  // R11
  kpos_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.elemCommit |-> kReg < 7'd64);
endmodule

// File: rtl/dc_dezigzag_dequant.sv
module dc_dezigzag_dequant
  import dzq_pkg::*;
#(
  parameter int MCU_AW = 9,
  parameter int CODE_AW = 11,
  parameter int STATE_AW = 10,
  parameter int LUMA_BLOCKS = 4,
  parameter int CHROMA_COMPS = 2,
  parameter logic [CODE_AW-1:0] QTAB_BASE = 'h700,
  parameter logic [STATE_AW-1:0] FRAME_DESC_BASE = 'h205,
  parameter logic [STATE_AW-1:0] DC_SAVE_BASE = 'h210
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                done,
  output logic [MCU_AW-1:0]   mcuRdAddr,
  input  logic [15:0]         mcuRdData,
  output logic                mcuWrEn,
  output logic [MCU_AW-1:0]   mcuWrAddr,
  output logic [15:0]         mcuWrData,
  output logic [CODE_AW-1:0]  qRdAddr,
  input  logic [7:0]          qRdData,
  output logic [STATE_AW-1:0] stRdAddr,
  input  logic [15:0]         stRdData,
  output logic                stWrEn,
  output logic [STATE_AW-1:0] stWrAddr,
  output logic [15:0]         stWrData
);
  dqStrobe_t st;
  logic elemEnd, lastPos;

  dzq_control #(
    .MCU_AW(MCU_AW), .STATE_AW(STATE_AW), .LUMA_BLOCKS(LUMA_BLOCKS),
    .CHROMA_COMPS(CHROMA_COMPS), .FRAME_DESC_BASE(FRAME_DESC_BASE),
    .DC_SAVE_BASE(DC_SAVE_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .elemEnd(elemEnd), .lastPos(lastPos),
    .st(st), .done(done), .mcuRdAddr(mcuRdAddr), .mcuWrEn(mcuWrEn),
    .mcuWrAddr(mcuWrAddr), .stRdAddr(stRdAddr), .stWrEn(stWrEn), .stWrAddr(stWrAddr)
  );

  dzq_datapath #(.CODE_AW(CODE_AW), .QTAB_BASE(QTAB_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .mcuRdData(mcuRdData), .qRdData(qRdData),
    .stRdData(stRdData), .qRdAddr(qRdAddr), .wrData(mcuWrData),
    .saveData(stWrData), .elemEnd(elemEnd), .lastPos(lastPos)
  );
endmodule

// File: tb/dc_dezigzag_dequant_tb.sv
`timescale 1ns/1ps
module dc_dezigzag_dequant_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done, mcuWrEn, stWrEn;
  logic [8:0] mcuRdAddr, mcuWrAddr;
  logic [15:0] mcuRdData, mcuWrData, stRdData, stWrData;
  logic [10:0] qRdAddr;
  logic [7:0] qRdData;
  logic [9:0] stRdAddr, stWrAddr;

  int total = 0;
  int bad = 0;

  logic [15:0] mcuMem [0:383];
  logic [7:0] qMem [0:255];
  logic [15:0] stMem [0:1023];
  logic [15:0] expMem [0:383];
  int natOf [0:63];
  int predM [0:2];

  always #2.5 clk = ~clk;

  dc_dezigzag_dequant u_dut (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .mcuRdAddr(mcuRdAddr), .mcuRdData(mcuRdData), .mcuWrEn(mcuWrEn),
    .mcuWrAddr(mcuWrAddr), .mcuWrData(mcuWrData), .qRdAddr(qRdAddr),
    .qRdData(qRdData), .stRdAddr(stRdAddr), .stRdData(stRdData),
    .stWrEn(stWrEn), .stWrAddr(stWrAddr), .stWrData(stWrData)
  );

  always @(posedge clk) begin
    mcuRdData <= mcuMem[mcuRdAddr];
    qRdData <= qMem[qRdAddr[7:0]];
    stRdData <= stMem[stRdAddr];
    if (mcuWrEn) mcuMem[mcuWrAddr] <= mcuWrData;
    if (stWrEn) stMem[stWrAddr] <= stWrData;
  end

  function automatic int sx16(input int x);
    logic [15:0] t;
    t = x[15:0];
    return {{16{t[15]}}, t};
  endfunction

  function automatic int sx12(input logic [11:0] a);
    return {{20{a[11]}}, a};
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference: diagonals of constant r+c, alternating direction
  task automatic buildNat();
    int idx = 0;
    for (int s = 0; s < 15; s++) begin
      int lo = (s > 7) ? s - 7 : 0;
      int hi = (s < 7) ? s : 7;
      if (s % 2 == 0) for (int r = hi; r >= lo; r--) begin natOf[idx] = r * 8 + (s - r); idx++; end
      else for (int r = lo; r <= hi; r++) begin natOf[idx] = r * 8 + (s - r); idx++; end
    end
  endtask

  task automatic fillQ(input int mode);
    for (int i = 0; i < 256; i++)
      qMem[i] <= (mode == 0) ? 8'd1 : (mode == 1) ? 8'(((i / 64) * 37 + (i % 64) * 3) % 200 + 1) : 8'd255;
  endtask

  task automatic setState(input int t0, t1, t2, p0, p1, p2);
    stMem[10'h205] <= {8'h22, 8'(t0)};
    stMem[10'h206] <= {8'h11, 8'(t1)};
    stMem[10'h207] <= {8'h11, 8'(t2)};
    stMem[10'h210] <= 16'(p0);
    stMem[10'h211] <= 16'(p1);
    stMem[10'h212] <= 16'(p2);
  endtask

  task automatic garbageMcu();
    for (int i = 0; i < 384; i++) mcuMem[i] <= 16'h5A5A;
  endtask

  task automatic modelMcu();
    for (int c = 0; c < 3; c++) predM[c] = sx16(int'(stMem[10'h210 + c]));
    for (int b = 0; b < 6; b++) begin
      int c = (b < 4) ? 0 : b - 3;
      int t = int'(stMem[10'h205 + c][1:0]);
      int k = 0;
      for (int i = 0; i < 64; i++) expMem[b * 64 + i] = 16'h0000;
      for (int e = 0; e < 64; e++) begin
        logic [15:0] el = mcuMem[b * 64 + e];
        int v, p;
        if (k > 0 && el == 16'h0000) break;
        if (k == 0) begin
          predM[c] = sx16(predM[c] + sx12(el[11:0]));
          v = predM[c];
        end else begin
          k = k + int'(el[15:12]);
          if (k > 63) break;
          v = sx12(el[11:0]);
        end
        p = v * int'(qMem[t * 64 + k]);
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        expMem[b * 64 + natOf[k]] = p[15:0];
        k++;
        if (k == 64) break;
      end
    end
  endtask

  task automatic runAndCheck(input string tag);
    @(negedge clk);
    modelMcu();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    // R10: done lasts one cycle
    check("R10", int'(done), 0, "done pulse width");
    for (int b = 0; b < 6; b++) begin
      int errs = 0;
      int firstA = 0, firstE = 0;
      for (int i = 0; i < 64; i++)
        if (mcuMem[b * 64 + i] !== expMem[b * 64 + i]) begin
          if (errs == 0) begin firstA = int'(mcuMem[b * 64 + i]); firstE = int'(expMem[b * 64 + i]); end
          errs++;
        end
      check(tag, firstA, firstE, $sformatf("block %0d first bad word (%0d bad)", b, errs));
    end
    for (int c = 0; c < 3; c++)
      check("R9", sx16(int'(stMem[10'h210 + c])), predM[c], $sformatf("saved predictor comp %0d", c));
  endtask

  // R1: idle outputs after reset
  task automatic tReset();
    @(negedge clk);
    check("R1", int'({done, mcuWrEn, stWrEn}), 0, "idle outputs");
  endtask

  // R6 (DC chain, DC run ignored), R5 (layout), R9 (restore from state)
  task automatic tDcChain(input bit loadState);
    fillQ(0);
    if (loadState) setState(0, 1, 1, 100, -50, 7);
    garbageMcu();
    @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      mcuMem[b * 64] <= {(b == 2) ? 4'h3 : 4'h0, 12'(b * 9 - 20)};
      mcuMem[b * 64 + 1] <= 16'h0000;
    end
    runAndCheck("R5/R6");
  endtask

  // R2 (run/amp), R3 (raster placement), R4 (EOB, ZRL), R7 (table select)
  task automatic tAcMix();
    fillQ(1);
    setState(2, 3, 0, -3, 12, 0);
    garbageMcu();
    @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      mcuMem[b * 64] <= {4'h0, 12'(b * 5 - 7)};
      for (int i = 0; i < 6; i++)
        mcuMem[b * 64 + 1 + i] <= {4'((i * 3 + b) % 6), 12'(i * 17 - 40)};
      mcuMem[b * 64 + 7] <= 16'hF000;
      mcuMem[b * 64 + 8] <= {4'h2, 12'h007};
      mcuMem[b * 64 + 9] <= 16'h0000;
    end
    runAndCheck("R2/R3/R4/R7");
  endtask

  // R11: block filled by 64 elements with no end marker
  task automatic tFull();
    fillQ(1);
    setState(1, 0, 2, 0, 0, 0);
    garbageMcu();
    @(negedge clk);
    for (int i = 0; i < 64; i++) mcuMem[i] <= {4'h0, 12'(i + 1)};
    for (int b = 1; b < 6; b++) begin
      mcuMem[b * 64] <= {4'h0, 12'(b)};
      mcuMem[b * 64 + 1] <= {4'h1, 12'hFF0};
      mcuMem[b * 64 + 2] <= 16'h0000;
    end
    runAndCheck("R11");
  endtask

  // R8: saturation of large products
  task automatic tSat();
    fillQ(2);
    setState(0, 0, 0, 0, -1000, 1000);
    garbageMcu();
    @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      mcuMem[b * 64] <= {4'h0, 12'h7FF};
      mcuMem[b * 64 + 1] <= {4'h0, 12'h800};
      mcuMem[b * 64 + 2] <= {4'h0, 12'd100};
      mcuMem[b * 64 + 3] <= {4'h4, 12'hFFF};
      mcuMem[b * 64 + 4] <= {4'h0, 12'd129};
      mcuMem[b * 64 + 5] <= 16'h0000;
    end
    runAndCheck("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog: done actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    buildNat();
    for (int i = 0; i < 1024; i++) stMem[i] <= 16'h0000;
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tDcChain(1'b1);
    tDcChain(1'b0);
    tAcMix();
    tFull();
    tSat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule